// File: doc/BRIEF.md
# Flag Threshold Register Port

This block holds the two thresholds that a FIFO's near-empty and near-full flag comparators use. It has no address. The thresholds are reached through the FIFO's own data buses, and an implicit selector switches back and forth between them. While the configure input `cfg_en` is high, each enabled write-clock edge stores the low bits of the write bus into one threshold. The first such edge writes the empty-side threshold, the next writes the full-side threshold, and the sequence repeats. Enabled read-clock edges return the thresholds on the read bus in the same alternating order. A separate selector in the read domain tracks that order.

While `cfg_en` is high, the block also blocks the FIFO's normal pointer-advance strobes on both ports. Configuration accesses therefore never move the FIFO itself. Reset restores both thresholds to their defaults and points both selectors at the empty-side threshold. Each selector keeps its position when `cfg_en` falls, so a later configuration burst continues where the last one stopped.

Top module: `flag_ofs_port`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets both thresholds to their defaults (127 each), clears rd_data to 0 and points both selectors at the empty-side threshold. Reset wins over any access in the same cycle.
- R2: A write-clock edge with cfg_en=1 and wr_en=1, with the write selector at the empty side, stores wr_data[13:0] into ae_ofs. Bits 17:14 are ignored.
- R3: Configuration writes alternate: the 1st goes to ae_ofs, the 2nd to af_ofs and the 3rd to ae_ofs again. Each write changes only one threshold.
- R4: With cfg_en=1 and wr_en=0, a write-clock edge changes neither threshold and does not advance the write selector.
- R5: With cfg_en=0 and wr_en=1, neither threshold changes and fifo_wr_go is 1.
- R6: While cfg_en=1, fifo_wr_go and fifo_rd_go are both 0, whatever the enables are.
- R7: A read-clock edge with cfg_en=1 and rd_en=1 loads rd_data with the threshold under the read selector, zero-extended: ae_ofs first, then af_ofs, alternating. The read selector is independent of the write selector.
- R8: With cfg_en=0 and rd_en=1, rd_data holds its value and fifo_rd_go is 1.
- R9: A selector keeps its position across a period with cfg_en=0. If a single threshold is written and cfg_en is then dropped, the other threshold keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| cfg_en | input | 1 | Configure mode: accesses target the thresholds |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Shared write bus |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Registered threshold readout |
| ae_ofs | output | OFS_W | Empty-side threshold |
| af_ofs | output | OFS_W | Full-side threshold |
| fifo_wr_go | output | 1 | FIFO write-pointer advance strobe |
| fifo_rd_go | output | 1 | FIFO read-pointer advance strobe |

## Verification
The advance strobes are combinational and are due in the same cycle as the enables. The bench samples them one nanosecond after it drives the inputs and before the next rising edge. A threshold write and a readout each go through one register, so the bench samples ae_ofs, af_ofs and rd_data one nanosecond after the rising edge that performs the access. Inputs change on falling edges only, so each vector matches exactly one active edge.

// File: rtl/ofsreg_pkg.sv
package ofsreg_pkg;
  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  localparam int unsigned NUM_OFS = 2;
endpackage

// File: rtl/ofs_sel_seq.sv
module ofs_sel_seq
  import ofsreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  output ofs_sel_e sel
);
  always_ff @(posedge clk) begin
    if (rst)      sel <= SEL_EMPTY;
    else if (adv) sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  end
endmodule

// File: rtl/ofs_store.sv
module ofs_store
  import ofsreg_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 14,
  parameter int unsigned AE_DEF = 127,
  parameter int unsigned AF_DEF = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  ofs_sel_e          sel,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  ae,
  output logic [OFS_W-1:0]  af
);
  logic [OFS_W-1:0] regs [NUM_OFS];

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_reg
    localparam logic [OFS_W-1:0] DEF = (i == 0) ? OFS_W'(AE_DEF) : OFS_W'(AF_DEF);
    always_ff @(posedge clk) begin
      if (rst)                             regs[i] <= DEF;
      else if (we && (int'(sel) == i))     regs[i] <= din[OFS_W-1:0];
    end
  end

  assign ae = regs[SEL_EMPTY];
  assign af = regs[SEL_FULL];
endmodule

// File: rtl/ofs_readout.sv
module ofs_readout
  import ofsreg_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  ofs_sel_e          sel,
  input  logic [OFS_W-1:0]  ae,
  input  logic [OFS_W-1:0]  af,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned PAD_W = DATA_W - OFS_W;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= {{PAD_W{1'b0}}, (sel == SEL_EMPTY) ? ae : af};
  end
endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port
  import ofsreg_pkg::*;
#(
  parameter int unsigned DATA_W     = 18,
  parameter int unsigned OFS_W      = 14,
  parameter int unsigned AE_DEFAULT = 127,
  parameter int unsigned AF_DEFAULT = 127
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic              fifo_wr_go,
  output logic              fifo_rd_go
);
  logic     cfg_wr, cfg_rd;
  ofs_sel_e wsel, rsel;

  assign cfg_wr     = cfg_en & wr_en;
  assign cfg_rd     = cfg_en & rd_en;
  assign fifo_wr_go = wr_en & ~cfg_en;
  assign fifo_rd_go = rd_en & ~cfg_en;

  ofs_sel_seq u_wsel (.clk(wr_clk), .rst(rst), .adv(cfg_wr), .sel(wsel));
  ofs_sel_seq u_rsel (.clk(rd_clk), .rst(rst), .adv(cfg_rd), .sel(rsel));

  ofs_store #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .AE_DEF(AE_DEFAULT), .AF_DEF(AF_DEFAULT)
  ) u_store (
    .clk(wr_clk), .rst(rst), .we(cfg_wr), .sel(wsel), .din(wr_data),
    .ae(ae_ofs), .af(af_ofs)
  );

  ofs_readout #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk(rd_clk), .rst(rst), .re(cfg_rd), .sel(rsel), .ae(ae_ofs), .af(af_ofs),
    .q(rd_data)
  );
endmodule

// File: rtl/flag_ofs_port_chk.sv
module flag_ofs_port_chk #(
  parameter int unsigned DATA_W     = 18,
  parameter int unsigned OFS_W      = 14,
  parameter int unsigned AE_DEFAULT = 127,
  parameter int unsigned AF_DEFAULT = 127
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFS_W-1:0]  ae_ofs,
  input logic [OFS_W-1:0]  af_ofs,
  input logic              fifo_wr_go,
  input logic              fifo_rd_go
);
  logic w_arm = 1'b0;
  logic r_arm = 1'b0;
  always_ff @(posedge wr_clk) if (rst) w_arm <= 1'b1;
  always_ff @(posedge rd_clk) if (rst) r_arm <= 1'b1;

  assert_rst_default_R1: assert property (@(posedge wr_clk) disable iff (!w_arm)
    rst |=> (ae_ofs == OFS_W'(AE_DEFAULT) && af_ofs == OFS_W'(AF_DEFAULT)));

  assert_write_lands_R2: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    (cfg_en && wr_en) |=> (ae_ofs == $past(wr_data[OFS_W-1:0]) ||
                           af_ofs == $past(wr_data[OFS_W-1:0])));

  assert_one_reg_R3: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    (cfg_en && wr_en) |=> ($stable(ae_ofs) || $stable(af_ofs)));

  assert_idle_hold_R4: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    !(cfg_en && wr_en) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  assert_block_go_R6: assert property (@(posedge wr_clk) disable iff (rst || !w_arm)
    cfg_en |-> (!fifo_wr_go && !fifo_rd_go));

  assert_rd_hold_R8: assert property (@(posedge rd_clk) disable iff (rst || !r_arm)
    !(cfg_en && rd_en) |=> $stable(rd_data));
endmodule

bind flag_ofs_port flag_ofs_port_chk #(
  .DATA_W(DATA_W), .OFS_W(OFS_W), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)
) u_chk (.*);

// File: tb/sim_flag_ofs_port.sv
module sim_flag_ofs_port;
  localparam int DW = 18;
  localparam int OW = 14;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cfg_en, wr_en, rd_en, fifo_wr_go, fifo_rd_go;
  logic [DW-1:0] wr_data, rd_data;
  logic [OW-1:0] ae_ofs, af_ofs;
  int n_chk = 0, n_fail = 0;

  flag_ofs_port u0 (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .cfg_en(cfg_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .ae_ofs(ae_ofs),
    .af_ofs(af_ofs), .fifo_wr_go(fifo_wr_go), .fifo_rd_go(fifo_rd_go)
  );

  // fields: req(4) cfg we re data(18) ae(14) af(14) q(18) wgo rgo = 73 bits
  localparam logic [72:0] VEC [NV] = '{
    {4'd2, 3'b110, 18'h30005, 14'h0005, 14'h007F, 18'h00000, 2'b00}, // R2 upper bits dropped
    {4'd3, 3'b110, 18'h00123, 14'h0005, 14'h0123, 18'h00000, 2'b00}, // R3 second to full
    {4'd4, 3'b100, 18'h03FFF, 14'h0005, 14'h0123, 18'h00000, 2'b00}, // R4 no write enable
    {4'd3, 3'b110, 18'h00200, 14'h0200, 14'h0123, 18'h00000, 2'b00}, // R3 third to empty
    {4'd5, 3'b010, 18'h01111, 14'h0200, 14'h0123, 18'h00000, 2'b10}, // R5 normal write
    {4'd7, 3'b101, 18'h00000, 14'h0200, 14'h0123, 18'h00200, 2'b00}, // R7 read empty side
    {4'd7, 3'b101, 18'h00000, 14'h0200, 14'h0123, 18'h00123, 2'b00}, // R7 read full side
    {4'd8, 3'b001, 18'h00000, 14'h0200, 14'h0123, 18'h00123, 2'b01}, // R8 normal read
    {4'd7, 3'b101, 18'h00000, 14'h0200, 14'h0123, 18'h00200, 2'b00}, // R7 wraps
    {4'd9, 3'b110, 18'h00777, 14'h0200, 14'h0777, 18'h00200, 2'b00}  // R9 selector kept
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic r, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_en = c; wr_en = w; rd_en = r; wr_data = d;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cfg_en = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 18'h00333;
    @(negedge clk); @(negedge clk); rst = 1'b0; cfg_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_en = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    do_reset();
    #1;
    chk(1, "reset ae", 32'(ae_ofs), 32'h7F);   // R1
    chk(1, "reset af", 32'(af_ofs), 32'h7F);   // R1
    chk(1, "reset q",  32'(rd_data), 32'h0);   // R1

    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      step(v[68], v[67], v[66], v[65:48]);
      #1;
      chk(int'(v[72:69]), "wr_go", 32'(fifo_wr_go), 32'(v[1]));
      chk(6, "rd_go (R6 gating)", 32'(fifo_rd_go), 32'(v[0]));
      @(posedge clk); #1;
      chk(int'(v[72:69]), "ae", 32'(ae_ofs), 32'(v[47:34]));
      chk(int'(v[72:69]), "af", 32'(af_ofs), 32'(v[33:20]));
      chk(int'(v[72:69]), "q",  32'(rd_data), 32'(v[19:2]));
    end

    // R1: reset restores defaults and selectors, overriding the access in the same cycle
    do_reset();
    #1;
    chk(1, "re-reset ae", 32'(ae_ofs), 32'h7F);
    chk(1, "re-reset af", 32'(af_ofs), 32'h7F);
    // R9: only one write, then leave configure mode
    step(1, 1, 0, 18'h00042); @(posedge clk); #1;
    step(0, 0, 0, 18'h0);     @(posedge clk); #1;
    chk(9, "single write ae", 32'(ae_ofs), 32'h42);
    chk(9, "untouched af",    32'(af_ofs), 32'h7F);
    // R1/R7: read selector restarts at the empty side after reset
    step(1, 0, 1, 18'h0); @(posedge clk); #1;
    chk(7, "read after reset first", 32'(rd_data), 32'h42);
    step(1, 0, 1, 18'h0); @(posedge clk); #1;
    chk(7, "read after reset second", 32'(rd_data), 32'h7F);
    // R6: both enables with configure high
    step(1, 1, 1, 18'h01234); #1;
    chk(6, "wr_go blocked", 32'(fifo_wr_go), 32'h0);
    chk(6, "rd_go blocked", 32'(fifo_rd_go), 32'h0);
    @(posedge clk); #1;
    chk(3, "second write to af", 32'(af_ofs), 32'h1234);
    chk(7, "third read empty side", 32'(rd_data), 32'h42);
    step(0, 0, 0, 18'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule